// File: doc/BRIEF.md
# Clock Replacement Engine with Aging History

This block keeps the replacement bookkeeping for a fixed set of physical page frames and picks victims when the free pool runs low. Each frame carries four pieces of state: a usage flag, a dirty flag, a fresh-arrival flag and a history register of configurable length. A processor-side strobe marks a frame as referenced. A write reference also marks it dirty. A fill strobe marks a frame as newly loaded.

A replenish request starts a sweep. A circular pointer visits one frame per clock cycle. At each visit the usage flag is aged into the history register, and the frame is either kept or evicted. The sweep stops once a fixed number of victims has been found. Each victim is reported with its index and a flag that says whether it must be written back or can go straight to the free pool.

A history length of zero turns the engine into a plain first-in-first-out selector. Longer histories approach least-recently-used ordering, at the cost of more pointer travel per sweep.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset every frame is resident with usage, dirty, fresh-arrival and history all zero, the pointer is at frame 0, and `busy`, `vic_valid` and `done` are low.
- R2: A strobe on `ref_valid` sets the usage flag of `ref_frame`. When `ref_write` is also high it sets that frame's dirty flag too. A reference to a frame that has been evicted and not yet refilled has no effect.
- R3: When the pointer visits a resident frame whose fresh-arrival flag is clear, the history is shifted one place toward its least significant bit and the usage flag enters at its most significant bit. A nonzero result keeps the frame. A zero result evicts it.
- R4: During a sweep the pointer advances by exactly one frame per cycle, wrapping from the last frame to frame 0. The pointer position is kept between sweeps. Every resident frame that is visited has its usage flag cleared. Evicted frames are passed over but still take a cycle.
- R5: A visited resident frame whose fresh-arrival flag is set has that flag and its usage flag cleared. The frame is kept and its history is left unchanged.
- R6: A strobe on `load_valid` makes `load_frame` resident again. It sets the fresh-arrival flag and clears the usage flag, the dirty flag and the history.
- R7: An eviction is reported one cycle after the visit that decided it. In that cycle `vic_valid` is high for one cycle, `vic_frame` holds the index, and `vic_push` is 1 if the frame was dirty (write-back needed) or 0 if it can be freed directly. The first visit takes place in the cycle after the request is accepted.
- R8: A sweep ends after exactly NVICT evictions. `done` is high together with the final `vic_valid`, and `busy` is low in that same cycle.
- R9: With HIST_W = 0 every visited resident frame whose fresh-arrival flag is clear is evicted, which gives first-in-first-out order.
- R10: `busy` is high while a sweep runs. A request that arrives while `busy` is high is ignored and does not start a further sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference strobe |
| ref_frame | input | FW | Frame being referenced |
| ref_write | input | 1 | Reference is a write |
| load_valid | input | 1 | Fill strobe |
| load_frame | input | FW | Frame just filled |
| repl_req | input | 1 | Start a replenish sweep |
| busy | output | 1 | Sweep in progress |
| vic_valid | output | 1 | Victim report strobe |
| vic_frame | output | FW | Victim frame index |
| vic_push | output | 1 | 1 = write back, 0 = free directly |
| done | output | 1 | Last victim of the sweep |

## Verification
A request driven before clock edge E0 is accepted at E0, so `busy` is high from E0 onward. The visit of sweep step v happens at edge E(v+1), and its report is registered there, so the report is sampled at the falling edge after E(v+1). The bench runs a reference model that produces the expected outcome of every sweep step. It checks `vic_valid`, `vic_frame`, `vic_push`, `done` and `busy` at each of those falling edges, for a history length of 2 and of 0 driven side by side. The request is held high until the shorter of the two sweeps has ended, and the bench then confirms that neither engine starts again.

// File: rtl/crepl_pkg.sv
package crepl_pkg;

   // index width for a count of n items, never below one bit
   function automatic int unsigned idx_w(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/crepl_frame.sv
module crepl_frame #(
   parameter int HIST_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_hit,
   input  logic ref_wr,
   input  logic load,
   input  logic visit,
   output logic take,
   output logic dirty,
   output logic gone
);

   logic use_q;
   logic fresh_q;
   logic hist_zero;

   generate
      if (HIST_W == 0) begin : g_fifo
         assign hist_zero = 1'b1;
      end else begin : g_age
         logic [HIST_W-1:0] hist_q;
         logic [HIST_W:0]   cat;
         assign cat       = {use_q, hist_q};
         assign hist_zero = (cat[HIST_W:1] == '0);

         always_ff @(posedge clk) begin
            if (!rst_n)                            hist_q <= '0;
            else if (load)                         hist_q <= '0;
            else if (visit && !gone && !fresh_q)   hist_q <= cat[HIST_W:1];
         end

         // R5
         fresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (visit && !gone && fresh_q && !load) |=> $stable(hist_q));
      end
   endgenerate

   assign take = visit & ~gone & ~fresh_q & ~load & hist_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_q   <= 1'b0;
         fresh_q <= 1'b0;
         dirty   <= 1'b0;
         gone    <= 1'b0;
      end else if (load) begin
         use_q   <= 1'b0;
         fresh_q <= 1'b1;
         dirty   <= 1'b0;
         gone    <= 1'b0;
      end else begin
         if (visit && !gone) begin
            use_q <= 1'b0;
            if (fresh_q) fresh_q <= 1'b0;
            if (take)    gone    <= 1'b1;
         end
         if (ref_hit && !gone) begin
            use_q <= 1'b1;
            if (ref_wr) dirty <= 1'b1;
         end
      end
   end

   // R6
   load_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (fresh_q && !gone && !dirty && !use_q));
   // R2
   ref_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit && !gone && !load) |=> use_q);
   // R2
   ref_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit && ref_wr && !gone && !load) |=> dirty);
   // R4
   visit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (visit && !ref_hit && !load) |=> !use_q);

endmodule

// File: rtl/crepl_sweep.sv
module crepl_sweep #(
   parameter int NFRAMES = 16,
   parameter int NVICT   = 3,
   parameter int FW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          repl_req,
   input  logic          pick,
   input  logic          pick_dirty,
   output logic [FW-1:0] ptr,
   output logic          busy,
   output logic          vic_valid,
   output logic [FW-1:0] vic_frame,
   output logic          vic_push,
   output logic          done
);

   localparam int CW = crepl_pkg::idx_w(NVICT + 1);

   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == CW'(NVICT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr       <= '0;
         busy      <= 1'b0;
         cnt       <= '0;
         vic_valid <= 1'b0;
         vic_frame <= '0;
         vic_push  <= 1'b0;
         done      <= 1'b0;
      end else if (!busy) begin
         vic_valid <= 1'b0;
         done      <= 1'b0;
         if (repl_req) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else begin
         ptr       <= (ptr == FW'(NFRAMES - 1)) ? '0 : ptr + 1'b1;
         vic_valid <= pick;
         vic_frame <= ptr;
         vic_push  <= pick_dirty;
         done      <= pick && last;
         if (pick) begin
            if (last) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
         end
      end
   end

   // R8
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < CW'(NVICT)));
   // R7
   report_follows_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> $past(busy));
   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr != FW'(NFRAMES - 1)) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine #(
   parameter int NFRAMES = 16,
   parameter int HIST_W  = 2,
   parameter int NVICT   = 3,
   localparam int FW     = crepl_pkg::idx_w(NFRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_valid,
   input  logic [FW-1:0] ref_frame,
   input  logic          ref_write,
   input  logic          load_valid,
   input  logic [FW-1:0] load_frame,
   input  logic          repl_req,
   output logic          busy,
   output logic          vic_valid,
   output logic [FW-1:0] vic_frame,
   output logic          vic_push,
   output logic          done
);

   generate
      if (NFRAMES < 2)                begin : g_bad_frames $error("NFRAMES must be at least 2"); end
      if (NVICT < 1 || NVICT > NFRAMES) begin : g_bad_vict $error("NVICT must lie in 1..NFRAMES"); end
      if (HIST_W < 0 || HIST_W > 16)  begin : g_bad_hist   $error("HIST_W must lie in 0..16"); end
   endgenerate

   logic [NFRAMES-1:0] take_vec;
   logic [NFRAMES-1:0] dirty_vec;
   logic [NFRAMES-1:0] gone_vec;
   logic [FW-1:0]      ptr;

   genvar f;
   generate
      for (f = 0; f < NFRAMES; f++) begin : g_frame
         crepl_frame #(.HIST_W(HIST_W)) u_frame (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_hit (ref_valid  && (ref_frame  == FW'(f))),
            .ref_wr  (ref_write),
            .load    (load_valid && (load_frame == FW'(f))),
            .visit   (busy && (ptr == FW'(f))),
            .take    (take_vec[f]),
            .dirty   (dirty_vec[f]),
            .gone    (gone_vec[f])
         );
      end
   endgenerate

   crepl_sweep #(.NFRAMES(NFRAMES), .NVICT(NVICT), .FW(FW)) u_sweep (
      .clk        (clk),
      .rst_n      (rst_n),
      .repl_req   (repl_req),
      .pick       (take_vec[ptr]),
      .pick_dirty (dirty_vec[ptr]),
      .ptr        (ptr),
      .busy       (busy),
      .vic_valid  (vic_valid),
      .vic_frame  (vic_frame),
      .vic_push   (vic_push),
      .done       (done)
   );

   // R8
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (vic_valid && !busy));
   // R7
   victim_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> gone_vec[vic_frame]);
   // R8
   one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_vec));

endmodule

// File: tb/clock_repl_engine_tb.sv
module clock_repl_engine_tb;

   localparam int NF = 16;
   localparam int NV = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_valid = 1'b0, ref_write = 1'b0, load_valid = 1'b0, repl_req = 1'b0;
   logic [3:0] ref_frame = '0, load_frame = '0;

   logic       o_busy[2];
   logic       o_vv[2];
   logic [3:0] o_vf[2];
   logic       o_vp[2];
   logic       o_done[2];

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   clock_repl_engine #(.NFRAMES(NF), .HIST_W(2), .NVICT(NV)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
      .ref_write(ref_write), .load_valid(load_valid), .load_frame(load_frame),
      .repl_req(repl_req), .busy(o_busy[0]), .vic_valid(o_vv[0]),
      .vic_frame(o_vf[0]), .vic_push(o_vp[0]), .done(o_done[0]));

   clock_repl_engine #(.NFRAMES(NF), .HIST_W(0), .NVICT(NV)) u_fifo (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
      .ref_write(ref_write), .load_valid(load_valid), .load_frame(load_frame),
      .repl_req(repl_req), .busy(o_busy[1]), .vic_valid(o_vv[1]),
      .vic_frame(o_vf[1]), .vic_push(o_vp[1]), .done(o_done[1]));

   // reference model, one copy per history length
   int kk[2] = '{2, 0};
   bit m_use[2][NF];
   bit m_mod[2][NF];
   bit m_ft[2][NF];
   bit m_out[2][NF];
   int m_hist[2][NF];
   int m_ptr[2];
   bit ev[2][256];
   int ef[2][256];
   bit ep[2][256];
   int ln[2];

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic plan(int i);
      int cnt = 0;
      ln[i] = 0;
      for (int v = 0; v < 256 && cnt < NV; v++) begin
         int f = m_ptr[i];
         ev[i][v] = 1'b0;
         if (!m_out[i][f]) begin
            if (m_ft[i][f]) begin
               m_ft[i][f] = 1'b0;
            end else begin
               int h = (kk[i] == 0) ? 0 :
                       ((m_hist[i][f] >> 1) | (int'(m_use[i][f]) << (kk[i] - 1)));
               m_hist[i][f] = h;
               if (h == 0) begin
                  ev[i][v] = 1'b1;
                  ef[i][v] = f;
                  ep[i][v] = m_mod[i][f];
                  m_out[i][f] = 1'b1;
                  cnt++;
               end
            end
            m_use[i][f] = 1'b0;
         end
         m_ptr[i] = (f + 1) % NF;
         ln[i] = v + 1;
      end
   endtask

   task automatic do_ref(int f, bit wr);
      @(negedge clk);
      ref_valid = 1'b1; ref_frame = 4'(f); ref_write = wr;
      for (int i = 0; i < 2; i++)
         if (!m_out[i][f]) begin
            m_use[i][f] = 1'b1;
            if (wr) m_mod[i][f] = 1'b1;
         end
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
   endtask

   task automatic do_load(int f);
      @(negedge clk);
      load_valid = 1'b1; load_frame = 4'(f);
      for (int i = 0; i < 2; i++) begin
         m_out[i][f] = 1'b0; m_ft[i][f] = 1'b1; m_hist[i][f] = 0;
         m_mod[i][f] = 1'b0; m_use[i][f] = 1'b0;
      end
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   task automatic do_sweep();
      int lmin, lmax;
      @(negedge clk);
      repl_req = 1'b1;
      plan(0); plan(1);
      lmin = (ln[0] < ln[1]) ? ln[0] : ln[1];
      lmax = (ln[0] > ln[1]) ? ln[0] : ln[1];
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk(o_busy[i] == 1'b1, "R10 busy after accept", int'(o_busy[i]), 1);
         chk(o_vv[i] == 1'b0, "R7 no report before first visit", int'(o_vv[i]), 0);
      end
      for (int v = 0; v < lmax; v++) begin
         @(negedge clk);
         for (int i = 0; i < 2; i++) begin
            if (v < ln[i]) begin
               if (i == 0) chk(o_vv[i] == ev[i][v], "R2 R3 R5 R6 evict decision", int'(o_vv[i]), int'(ev[i][v]));
               else        chk(o_vv[i] == ev[i][v], "R9 fifo evict decision", int'(o_vv[i]), int'(ev[i][v]));
               if (ev[i][v]) begin
                  chk(int'(o_vf[i]) == ef[i][v], "R4 victim index", int'(o_vf[i]), ef[i][v]);
                  chk(o_vp[i] == ep[i][v], "R7 push flag", int'(o_vp[i]), int'(ep[i][v]));
               end
               chk(o_done[i] == (v == ln[i] - 1), "R8 done timing", int'(o_done[i]), int'(v == ln[i] - 1));
               chk(o_busy[i] == (v < ln[i] - 1), "R8 busy drop", int'(o_busy[i]), int'(v < ln[i] - 1));
            end else begin
               chk(o_vv[i] == 1'b0 && o_busy[i] == 1'b0, "R10 held request ignored",
                   int'(o_vv[i]) + 2 * int'(o_busy[i]), 0);
            end
         end
         if (v == lmin - 1) repl_req = 1'b0;
      end
      @(negedge clk);
      for (int i = 0; i < 2; i++)
         chk(o_busy[i] == 1'b0 && o_vv[i] == 1'b0, "R10 no restart",
             int'(o_busy[i]) + 2 * int'(o_vv[i]), 0);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_ptr[i] = 0;
         for (int f = 0; f < NF; f++) begin
            m_use[i][f] = 0; m_mod[i][f] = 0; m_ft[i][f] = 0;
            m_out[i][f] = 0; m_hist[i][f] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk(o_busy[i] == 0, "R1 busy idle", int'(o_busy[i]), 0);
         chk(o_vv[i] == 0, "R1 no victim", int'(o_vv[i]), 0);
         chk(o_done[i] == 0, "R1 done low", int'(o_done[i]), 0);
      end
      // R1: fresh state, first sweep takes frames from 0 upward
      do_sweep();
      for (int r = 0; r < 40; r++) begin
         // references, some aimed at evicted frames (R2)
         for (int f = 0; f < NF; f++)
            if (((r * 7 + f * 3) % 5) < 2) do_ref(f, ((r + f) % 3) == 0);
         // refill evicted frames (R6)
         for (int f = 0; f < NF; f++)
            if ((m_out[0][f] || m_out[1][f]) && ((r + f) % 4 != 3 || r > 30)) do_load(f);
         // references right after fill, masked by the fresh flag (R5)
         for (int f = 0; f < NF; f += 5) do_ref(f, (r % 2) == 1);
         do_sweep();
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule